// File: doc/BRIEF.md
# Twin Gated-Strobe Up Counter

The block contains two independent binary up counters, channel A and channel B. Each channel has two count-control pins. One pin advances the count on its rising edge, and the other advances it on its falling edge. Each edge counts only when the opposite pin is at its enabling level. Either pin can therefore act as the count strobe while the other acts as the count gate. Each channel also has an active-high clear that overrides everything else.

All control pins are treated as asynchronous. They are brought into a single fast system clock domain through a multi-stage synchronizer, and their edges are found in that domain. The clear forces the count to zero at once, without waiting for the clock. It is released cleanly on the system clock, and a short dead period after the release stops a half-seen edge from counting. The count bits are driven straight from the counter registers.

Top module: `twin_gated_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, both counts become 0 and all control pins are ignored.
- R2: A low-to-high change on a channel's rise pin adds one to that channel's count if its fall pin was high in the synchronized sample just before the change.
- R3: A high-to-low change on a channel's fall pin adds one to that channel's count if its rise pin was low in the synchronized sample just before the change.
- R4: These edges leave the count unchanged: a rise-pin rising edge while the fall pin was low, a fall-pin falling edge while the rise pin was high, a falling edge of the rise pin, and a rising edge of the fall pin.
- R5: The rise pin may rise in the same sample in which the fall pin falls, after a sample with the rise pin low and the fall pin high. In that case the count goes up by exactly one.
- R6: The count is plain binary, CNT_W bits wide (4 by default), and goes from all ones to zero on the next qualified edge.
- R7: When a channel's clear goes high, that channel's count reads 0 before the next `clk` edge. It stays 0 for as long as the clear is high, whatever the pins do.
- R8: After the clear is sampled low, the count stays 0 through that edge and the next CLR_STAGES edges (3 edges with defaults). A qualified edge whose step falls on the last of those edges is lost.
- R9: The count changes on the (SYNC_STAGES+1)-th rising `clk` edge after a qualifying pin change is first sampled. With the defaults this is the third edge.
- R10: The two channels are independent. Pins and clear of one channel never change the other channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Synchronous active-low block reset |
| a_rise_in | input | 1 | Channel A pin that counts on its rising edge |
| a_fall_in | input | 1 | Channel A pin that counts on its falling edge |
| a_clear | input | 1 | Channel A clear, active high, takes effect at once |
| b_rise_in | input | 1 | Channel B pin that counts on its rising edge |
| b_fall_in | input | 1 | Channel B pin that counts on its falling edge |
| b_clear | input | 1 | Channel B clear, active high, takes effect at once |
| a_count | output | CNT_W | Channel A count |
| b_count | output | CNT_W | Channel B count |

## Verification
The assertions assume the pins and the clears are low while `rst_n` is low. They also assume that every level on a pin is held for several `clk` periods, so that the synchronizer sees each edge as exactly one step. The bench changes every input 2 ns after a rising edge and holds each level for at least one full sample window. Before `rst_n` is released it parks all inputs low. Each clear pulse is kept longer than a clock period. The release and latency tests are timed to the exact edge the requirements name.

// File: rtl/tgc_pkg.sv
// Package: shared defaults and types for the twin gated-strobe counter.
// Assumes: nothing; holds only constants and a pin-pair struct.
package tgc_pkg;
    localparam int TGC_CNT_W      = 4;
    localparam int TGC_SYNC_DEPTH = 2;
    localparam int TGC_CLR_DEPTH  = 2;
    localparam int TGC_NUM_CH     = 2;

    // One channel's pair of count-control pins
    typedef struct packed {
        logic rise;
        logic fall;
    } tgc_pins_t;
endpackage

// File: rtl/tgc_sync.sv
// Module: multi-stage level synchronizer for a small vector of pins.
// Assumes: input pins are asynchronous; each held longer than one clock.
module tgc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pin levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/tgc_edge_qual.sv
// Module: finds edges on the synchronized pin pair and applies gating.
// Assumes: inputs are already in the clk domain. Gate levels are taken
// from the sample before the edge, so a simultaneous rise/fall yields
// a single step.
module tgc_edge_qual
    import tgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tgc_pins_t lvl_i,
    output logic      step_o
);
    tgc_pins_t prev_q;
    logic      rise_hit;
    logic      fall_hit;

    // Remember the previous synchronized sample
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // Qualify each edge with the other pin's prior level
    always_comb begin
        rise_hit = lvl_i.rise && !prev_q.rise && prev_q.fall;
        fall_hit = !lvl_i.fall && prev_q.fall && !prev_q.rise;
        step_o   = rise_hit || fall_hit;
    end
endmodule

// File: rtl/tgc_clear_ctl.sv
// Module: clear conditioner; asserts at once, releases on clk, then
// adds one settle cycle during which steps are dropped.
// Assumes: clear_i is low during rst_n reset.
module tgc_clear_ctl #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic hold_o,
    output logic settle_o
);
    logic [STAGES-1:0] rel_q;
    logic              settle_q;

    // Release pipeline, set without the clock by the clear
    always_ff @(posedge clk or posedge clear_i) begin
        if (clear_i)     rel_q <= '1;
        else if (!rst_n) rel_q <= '0;
        else             rel_q <= rel_q << 1;
    end

    // One extra cycle that blocks a step after the release
    always_ff @(posedge clk) begin
        if (!rst_n) settle_q <= 1'b0;
        else        settle_q <= hold_o;
    end

    assign hold_o   = rel_q[STAGES-1];
    assign settle_o = settle_q;
endmodule

// File: rtl/tgc_counter.sv
// Module: binary up counter with an immediate clear and a step gate.
// Assumes: hold_i comes from a conditioner that releases on clk.
module tgc_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             settle_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count qualified steps; zero on hold or reset, wrap at all ones
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i)                    cnt_q <= '0;
        else if (!rst_n)               cnt_q <= '0;
        else if (step_i && !settle_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tgc_channel.sv
// Module: one complete counting channel: synchronizer, edge gating,
// clear conditioning and counter.
// Assumes: pins are asynchronous to clk.
module tgc_channel
    import tgc_pkg::*;
#(
    parameter int CNT_W      = TGC_CNT_W,
    parameter int SYNC_DEPTH = TGC_SYNC_DEPTH,
    parameter int CLR_DEPTH  = TGC_CLR_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tgc_pins_t        pins_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    localparam int PIN_W = $bits(tgc_pins_t);

    tgc_pins_t lvl;
    logic      step;
    logic      hold;
    logic      settle;

    tgc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (lvl)
    );

    tgc_edge_qual u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .step_o (step)
    );

    tgc_clear_ctl #(.STAGES(CLR_DEPTH)) u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .hold_o   (hold),
        .settle_o (settle)
    );

    tgc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (hold),
        .settle_i (settle),
        .step_i   (step),
        .cnt_o    (count_o)
    );
endmodule

// File: rtl/twin_gated_counter.sv
// Module: top level; two independent gated-strobe up counters.
// Assumes: all pin and clear inputs are asynchronous to clk and are
// low while rst_n is low.
module twin_gated_counter
    import tgc_pkg::*;
#(
    parameter int CNT_W      = TGC_CNT_W,
    parameter int SYNC_DEPTH = TGC_SYNC_DEPTH,
    parameter int CLR_DEPTH  = TGC_CLR_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_rise_in,
    input  logic             a_fall_in,
    input  logic             a_clear,
    input  logic             b_rise_in,
    input  logic             b_fall_in,
    input  logic             b_clear,
    output logic [CNT_W-1:0] a_count,
    output logic [CNT_W-1:0] b_count
);
    localparam int NCH = TGC_NUM_CH;

    tgc_pins_t        pins_arr [NCH];
    logic [NCH-1:0]   clr_arr;
    logic [CNT_W-1:0] cnt_arr  [NCH];

    // Gather the per-channel pins into arrays
    always_comb begin
        pins_arr[0] = '{rise: a_rise_in, fall: a_fall_in};
        pins_arr[1] = '{rise: b_rise_in, fall: b_fall_in};
        clr_arr     = {b_clear, a_clear};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        tgc_channel #(
            .CNT_W      (CNT_W),
            .SYNC_DEPTH (SYNC_DEPTH),
            .CLR_DEPTH  (CLR_DEPTH)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pins_i  (pins_arr[ch]),
            .clear_i (clr_arr[ch]),
            .count_o (cnt_arr[ch])
        );
    end

    assign a_count = cnt_arr[0];
    assign b_count = cnt_arr[1];
endmodule

// File: rtl/tgc_checker.sv
// Module: property checker bound to twin_gated_counter.
// Assumes: inputs obey the rules in the brief.
module tgc_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_clear,
    input logic             b_clear,
    input logic [CNT_W-1:0] a_count,
    input logic [CNT_W-1:0] b_count
);
    AST_A_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        a_clear |-> a_count == '0);                                   // R7
    AST_B_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        b_clear |-> b_count == '0);                                   // R7
    AST_A_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        a_count != $past(a_count) |-> (a_count == $past(a_count) + 1'b1) || (a_count == '0)); // R6
    AST_B_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        b_count != $past(b_count) |-> (b_count == $past(b_count) + 1'b1) || (b_count == '0)); // R6
    AST_A_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_clear) |=> a_count == '0);                            // R8
    AST_B_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_clear) |=> b_count == '0);                            // R8
endmodule

bind twin_gated_counter tgc_checker #(.CNT_W(CNT_W)) u_tgc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_clear (a_clear),
    .b_clear (b_clear),
    .a_count (a_count),
    .b_count (b_count)
);

// File: tb/twin_gated_counter_tb.sv
module twin_gated_counter_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   t_rise = '0;
    logic [1:0]   t_fall = '0;
    logic [1:0]   t_clr  = '0;
    logic [W-1:0] a_count;
    logic [W-1:0] b_count;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    twin_gated_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_rise_in (t_rise[0]),
        .a_fall_in (t_fall[0]),
        .a_clear   (t_clr[0]),
        .b_rise_in (t_rise[1]),
        .b_fall_in (t_fall[1]),
        .b_clear   (t_clr[1]),
        .a_count   (a_count),
        .b_count   (b_count)
    );

    // Reference model built from the requirements (R2 R3 R5 R8 R9)
    logic [1:0]   m_r0 = '0, m_r1 = '0, m_f0 = '0, m_f1 = '0, m_rp = '0, m_fp = '0;
    logic [W-1:0] m_cnt [2] = '{default: '0};
    int           m_blk [2] = '{default: 0};

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            logic st;
            st = (m_r1[c] && !m_rp[c] && m_fp[c]) || (!m_f1[c] && m_fp[c] && !m_rp[c]);
            if (!rst_n) begin
                m_r0[c] <= 1'b0; m_r1[c] <= 1'b0; m_f0[c] <= 1'b0; m_f1[c] <= 1'b0;
                m_rp[c] <= 1'b0; m_fp[c] <= 1'b0; m_cnt[c] <= '0; m_blk[c] <= 0;
            end else begin
                m_r0[c] <= t_rise[c]; m_r1[c] <= m_r0[c];
                m_f0[c] <= t_fall[c]; m_f1[c] <= m_f0[c];
                m_rp[c] <= m_r1[c];   m_fp[c] <= m_f1[c];
                if (t_clr[c]) begin
                    m_cnt[c] <= '0; m_blk[c] <= 3;
                end else if (m_blk[c] != 0) begin
                    m_blk[c] <= m_blk[c] - 1;
                end else if (st) begin
                    m_cnt[c] <= m_cnt[c] + 1'b1;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R9 R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 model chA", a_count, t_clr[0] ? '0 : m_cnt[0]);
            check("R10 model chB", b_count, t_clr[1] ? '0 : m_cnt[1]);
        end
    end

    task automatic drive(input int c, input logic r, input logic f, input logic cl);
        @(posedge clk); #2;
        t_rise[c] = r; t_fall[c] = f; t_clr[c] = cl;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Vector table: {rise, fall, clear, expected channel A count}
    localparam logic [6:0] VEC [0:18] = '{
        {3'b010, 4'd0},  // R4 fall pin rises
        {3'b110, 4'd1},  // R2 rise with fall high
        {3'b010, 4'd1},  // R4 rise pin falls
        {3'b110, 4'd2},  // R2
        {3'b010, 4'd2},
        {3'b000, 4'd3},  // R3 fall with rise low
        {3'b010, 4'd3},
        {3'b000, 4'd4},  // R3
        {3'b100, 4'd4},  // R4 rise with fall low
        {3'b110, 4'd4},  // R4
        {3'b100, 4'd4},  // R4 fall with rise high
        {3'b000, 4'd4},
        {3'b010, 4'd4},
        {3'b100, 4'd5},  // R5 simultaneous
        {3'b000, 4'd5},
        {3'b001, 4'd0},  // R7 clear
        {3'b011, 4'd0},  // R7 edges under clear
        {3'b111, 4'd0},  // R7
        {3'b110, 4'd0}   // R8 release, no new edge
    };

    initial begin
        settle(5);
        check("R1 reset chA", a_count, '0);
        check("R1 reset chB", b_count, '0);
        @(posedge clk); #2 rst_n = 1'b1;
        settle(3);

        for (int i = 0; i < 19; i++) begin
            drive(0, VEC[i][6], VEC[i][5], VEC[i][4]);
            settle(5);
            check("R2 R3 R4 R5 vector chA", a_count, VEC[i][3:0]);
            check("R10 chB untouched", b_count, '0);
        end

        // R9: latency of three clk edges
        drive(0, 1'b0, 1'b1, 1'b0);
        settle(5);
        @(posedge clk); #2 t_rise[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 not yet", a_count, 4'd0);
        @(negedge clk);
        check("R9 counted", a_count, 4'd1);

        // R6: wrap on channel B with the fall pin as strobe
        drive(1, 1'b0, 1'b1, 1'b0);
        settle(5);
        for (int k = 1; k <= 17; k++) begin
            drive(1, 1'b0, 1'b0, 1'b0); settle(4);
            if (k == 15) check("R6 at max", b_count, 4'd15);
            if (k == 16) check("R6 wrapped", b_count, 4'd0);
            if (k == 17) check("R6 after wrap", b_count, 4'd1);
            drive(1, 1'b0, 1'b1, 1'b0); settle(4);
        end
        check("R10 chA untouched", a_count, 4'd1);

        // R7: clear acts before the next clock edge
        drive(0, 1'b0, 1'b1, 1'b0); settle(4);
        drive(0, 1'b1, 1'b1, 1'b0); settle(4);
        check("R7 before clear", a_count, 4'd2);
        @(posedge clk); #2 t_clr[0] = 1'b1;
        #1 check("R7 immediate", a_count, 4'd0);
        check("R10 chB during A clear", b_count, 4'd1);

        // R8: edge landing on the settle edge is lost
        drive(0, 1'b0, 1'b1, 1'b1); settle(4);
        drive(0, 1'b1, 1'b1, 1'b0); settle(6);
        check("R8 lost edge", a_count, 4'd0);
        drive(0, 1'b0, 1'b1, 1'b1); settle(4);
        drive(0, 1'b0, 1'b1, 1'b0);
        @(posedge clk); #2 t_rise[0] = 1'b1;
        settle(6);
        check("R8 edge after settle", a_count, 4'd1);

        // R1: reset mid-count
        @(posedge clk); #2 rst_n = 1'b0;
        settle(2);
        check("R1 mid reset chA", a_count, 4'd0);
        check("R1 mid reset chB", b_count, 4'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule